// File: doc/BRIEF.md
# Slot Reference Clock Generator with Pin Takeover

This block produces a divided copy of the master clock for each daughterboard side and routes it onto one general-purpose I/O pin of that side (pin 0) in place of the pin's normal function. Each side owns a 32-bit configuration word. The low seven bits give a divisor. The bit above them switches the clock output on. When that bit is set, the reference pin carries the divided clock and is driven as an output. When it is clear, the pin returns to ordinary GPIO control.

The block sits between a GPIO bank and the pads. The bank supplies per-pin output data and output enables. This block passes them through unchanged, except on the reference pin of any side whose clock is switched on. The divisor sets the half-period in master-clock cycles, so the output runs at f_clk / (2·divisor). A divisor change never cuts a half-period short. The new value is taken at the next output edge.

Top module: `refclk_pin_share`

## Requirements
- R1: While reset is asserted and after it is released, every side is disabled, its divided clock is low, and all pad outputs and enables equal the GPIO bank's values.
- R2: Writing a configuration word with bit 7 = 1 to a side takes that side's pin 0 over. The pad stays low and then rises D clock edges after the edge that captured the write, where D is the effective divisor.
- R3: While enabled, the divided clock toggles every D master-clock cycles, with D taken from configuration bits 6:0. This covers values 1 to 127, and the period is 2·D cycles.
- R4: A divisor field of 0 behaves exactly like a divisor of 1 (toggle every cycle).
- R5: While a side is enabled, its pin 0 output enable is 1 whatever the GPIO bank requests.
- R6: Writing bit 7 = 0 returns pin 0 to GPIO output and enable from the cycle after the capturing edge. The divided clock is held low while disabled, so a later re-enable starts from low.
- R7: Configuration bits 31:8 have no effect on behaviour.
- R8: A divisor written while the clock runs does not shorten the current half-period. The running half-period completes with the old value, and the new value governs from the next output edge on.
- R9: The two sides have independent configuration words and dividers. A write to one side leaves the other side's pad behaviour unchanged.
- R10: Pins other than pin 0 always pass GPIO output data and output enable through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | NUM_SIDES | Per-side configuration write strobe |
| cfgWrData | input | CFG_WIDTH | Configuration word: bit 7 enable, bits 6:0 divisor, upper bits ignored |
| gpioOut | input | NUM_SIDES*IO_WIDTH | GPIO bank output data, side s at bits [s*IO_WIDTH +: IO_WIDTH] |
| gpioOe | input | NUM_SIDES*IO_WIDTH | GPIO bank output enables, same layout |
| padOut | output | NUM_SIDES*IO_WIDTH | Output data to pads |
| padOe | output | NUM_SIDES*IO_WIDTH | Output enables to pads |

## Verification
The bench uses the default parameters: two sides of sixteen pins each, the reference on pin 0, and a 32-bit configuration word. This setup lets one run cover the whole seven-bit divisor range, including 0, 1, 2, 7 and 127. It also keeps both sides running at unrelated rates at the same time, which exposes any crosstalk between them. The GPIO inputs are scrambled every cycle. As a result, the takeover, the forced enable and the pass-through of the other fifteen pins are all compared against changing data.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int DIV_W = 7;

  typedef struct packed {
    logic             run;
    logic [DIV_W-1:0] divVal;
  } refCtrl_t;
endpackage

// File: rtl/refclk_ctrl.sv
module refclk_ctrl
  import refclk_pkg::*;
#(
  parameter int CFG_WIDTH = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [CFG_WIDTH-1:0] cfgWrData,
  output refCtrl_t             ctrl
);
  localparam int EN_BIT = DIV_W;

  logic             cfgEn;
  logic [DIV_W-1:0] cfgDiv;
  logic             unusedRsvd;

  // upper bits are reserved and intentionally dropped
  assign unusedRsvd = ^cfgWrData[CFG_WIDTH-1:EN_BIT+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn  <= 1'b0;
      cfgDiv <= '0;
    end else if (cfgWrEn) begin
      cfgEn  <= cfgWrData[EN_BIT];
      cfgDiv <= cfgWrData[DIV_W-1:0];
    end
  end

  assign ctrl.run    = cfgEn;
  assign ctrl.divVal = cfgDiv;

  // R6: a disabling write releases the pin on the next cycle
  assert_disable_now_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgWrData[EN_BIT]) |=> !ctrl.run);
endmodule

// File: rtl/refclk_datapath.sv
module refclk_datapath
  import refclk_pkg::*;
#(
  parameter int IO_WIDTH = 16,
  parameter int REF_PIN  = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  refCtrl_t            ctrl,
  input  logic [IO_WIDTH-1:0] gpioOut,
  input  logic [IO_WIDTH-1:0] gpioOe,
  output logic [IO_WIDTH-1:0] padOut,
  output logic [IO_WIDTH-1:0] padOe
);
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] curDiv;
  logic [DIV_W-1:0] effDiv;
  logic             clkQ;
  logic             startedQ;
  logic             halfDone;

  // first running cycle uses the freshly written divisor
  assign curDiv   = startedQ ? activeDiv : ctrl.divVal;
  assign effDiv   = (curDiv == '0) ? DIV_W'(1) : curDiv;
  assign halfDone = (cnt == effDiv - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ      <= 1'b0;
      cnt       <= '0;
      startedQ  <= 1'b0;
      activeDiv <= '0;
    end else if (!ctrl.run) begin
      clkQ     <= 1'b0;
      cnt      <= '0;
      startedQ <= 1'b0;
    end else begin
      startedQ <= 1'b1;
      if (halfDone || !startedQ) activeDiv <= ctrl.divVal;
      if (halfDone) begin
        clkQ <= ~clkQ;
        cnt  <= '0;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  always_comb begin
    padOut = gpioOut;
    padOe  = gpioOe;
    if (ctrl.run) begin
      padOut[REF_PIN] = clkQ;
      padOe[REF_PIN]  = 1'b1;
    end
  end

  // R6: divided clock held low while the side is off
  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> !clkQ);

  // R8: the active divisor only changes on an output edge
  assert_no_runt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startedQ && $past(startedQ) && activeDiv != $past(activeDiv)) |-> clkQ != $past(clkQ));

  // R3: counter never runs past the half-period
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    startedQ |-> (cnt < ((activeDiv == '0) ? DIV_W'(1) : activeDiv)));

  // R5: pin is driven whenever the clock owns it
  assert_oe_forced_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.run |-> padOe[REF_PIN]);
endmodule

// File: rtl/refclk_pin_share.sv
module refclk_pin_share
  import refclk_pkg::*;
#(
  parameter int NUM_SIDES = 2,
  parameter int IO_WIDTH  = 16,
  parameter int CFG_WIDTH = 32,
  parameter int REF_PIN   = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SIDES-1:0]          cfgWrEn,
  input  logic [CFG_WIDTH-1:0]          cfgWrData,
  input  logic [NUM_SIDES*IO_WIDTH-1:0] gpioOut,
  input  logic [NUM_SIDES*IO_WIDTH-1:0] gpioOe,
  output logic [NUM_SIDES*IO_WIDTH-1:0] padOut,
  output logic [NUM_SIDES*IO_WIDTH-1:0] padOe
);
  for (genvar s = 0; s < NUM_SIDES; s++) begin : gSide
    refCtrl_t sideCtrl;

    refclk_ctrl #(.CFG_WIDTH(CFG_WIDTH)) uCtrl (
      .clk      (clk),
      .rstN     (rstN),
      .cfgWrEn  (cfgWrEn[s]),
      .cfgWrData(cfgWrData),
      .ctrl     (sideCtrl)
    );

    refclk_datapath #(.IO_WIDTH(IO_WIDTH), .REF_PIN(REF_PIN)) uDp (
      .clk    (clk),
      .rstN   (rstN),
      .ctrl   (sideCtrl),
      .gpioOut(gpioOut[s*IO_WIDTH +: IO_WIDTH]),
      .gpioOe (gpioOe[s*IO_WIDTH +: IO_WIDTH]),
      .padOut (padOut[s*IO_WIDTH +: IO_WIDTH]),
      .padOe  (padOe[s*IO_WIDTH +: IO_WIDTH])
    );
  end
endmodule

// File: tb/tb_refclk_pin_share.sv
module tb_refclk_pin_share;
  localparam int NS = 2;
  localparam int IW = 16;
  localparam int CW = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NS-1:0]    cfgWrEn = '0;
  logic [CW-1:0]    cfgWrData = '0;
  logic [NS*IW-1:0] gpioOut = '0;
  logic [NS*IW-1:0] gpioOe = '0;
  logic [NS*IW-1:0] padOut;
  logic [NS*IW-1:0] padOe;

  refclk_pin_share dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .padOut(padOut), .padOe(padOe)
  );

  always #2 clk = ~clk;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 0;
  bit    scramble = 0;
  string curReq = "R1";

  // behavioural model: per side enable, divisor, cycles left in half-period, level
  int mEn[NS], mDiv[NS], mLeft[NS], mLvl[NS];

  always @(posedge clk) begin
    for (int s = 0; s < NS; s++) begin
      if (!rstN) begin
        mEn[s] = 0; mDiv[s] = 0; mLeft[s] = 0; mLvl[s] = 0;
      end else begin
        if (mEn[s] == 0) begin
          mLvl[s] = 0; mLeft[s] = 0;
        end else begin
          if (mLeft[s] == 0) mLeft[s] = (mDiv[s] == 0) ? 1 : mDiv[s];
          mLeft[s] = mLeft[s] - 1;
          if (mLeft[s] == 0) begin
            mLvl[s]  = 1 - mLvl[s];
            mLeft[s] = (mDiv[s] == 0) ? 1 : mDiv[s];
          end
        end
        if (cfgWrEn[s]) begin
          mEn[s]  = cfgWrData[7] ? 1 : 0;
          mDiv[s] = int'(cfgWrData[6:0]);
        end
      end
    end
  end

  task automatic check(input string req, input int s, input string what,
                       input logic [IW-1:0] got, input logic [IW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s side%0d %s: actual %h expected %h", req, s, what, got, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int s = 0; s < NS; s++) begin
        logic [IW-1:0] eo, ee;
        eo = gpioOut[s*IW +: IW];
        ee = gpioOe[s*IW +: IW];
        if (mEn[s] != 0) begin
          eo[0] = mLvl[s][0];
          ee[0] = 1'b1;
        end
        check(curReq, s, "pin0 out", {15'b0, padOut[s*IW]}, {15'b0, eo[0]});
        check("R5", s, "pin0 oe", {15'b0, padOe[s*IW]}, {15'b0, ee[0]});
        check("R10", s, "other out", {padOut[s*IW+1 +: IW-1], 1'b0}, {eo[IW-1:1], 1'b0});
        check("R10", s, "other oe", {padOe[s*IW+1 +: IW-1], 1'b0}, {ee[IW-1:1], 1'b0});
      end
    end
  end

  always @(negedge clk) begin
    if (scramble) begin
      #1;
      gpioOut = {$urandom, $urandom} ;
      gpioOe  = {$urandom, $urandom};
    end
  end

  task automatic wr(input int s, input logic [CW-1:0] d);
    @(negedge clk); #1;
    cfgWrEn = '0; cfgWrEn[s] = 1'b1; cfgWrData = d;
    @(negedge clk); #1;
    cfgWrEn = '0; cfgWrData = '0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_up;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    gpioOut = 32'h1234_ABCD;
    gpioOe  = 32'h0F0F_5AA5;
    run(3);
    @(negedge clk);
    // R1: pads follow GPIO while in reset
    check("R1", 0, "reset out", padOut[IW-1:0], gpioOut[IW-1:0]);
    check("R1", 1, "reset oe", padOe[2*IW-1:IW], gpioOe[2*IW-1:IW]);
    #1 rstN = 1'b1;
    scramble = 1;
    run(5);
    curReq = "R2";  wr(0, 32'h0000_0083); run(30);   // D=3, takeover
    curReq = "R4";  wr(1, 32'h0000_0080); run(20);   // D=0 behaves as 1
    curReq = "R8";  wr(0, 32'h0000_0085); run(40);   // slower mid-run
    wr(0, 32'h0000_0081); run(20);                   // faster mid-run
    curReq = "R7";  wr(1, 32'hA5A5_A582); run(30);   // reserved garbage
    curReq = "R6";  wr(0, 32'h0000_0000); run(10);   // release pin
    wr(0, 32'h0000_0082); run(20);                   // restart low
    curReq = "R3";  wr(1, 32'h0000_0087); run(60);
    wr(1, 32'h0000_00FF); run(600);                  // D=127
    curReq = "R9";  wr(0, 32'h0000_0084); run(40);   // other side untouched
    wr(0, 32'hFFFF_FF05); run(20);                   // bit7=0 with junk
    run(2);
    finish_up();
  end
endmodule